// File: doc/BRIEF.md
# Memory-Aware Warp Issue Scheduler

This block picks at most one warp per cycle to issue from a pool of warps in a GPU shader core. Each warp reports whether its instruction buffer holds an instruction, whether that instruction is a memory or a compute operation, and whether the scoreboard holds it back. A warp is ready when it has an instruction and no dependency. The block returns a grant flag and the index of the chosen warp in the same cycle.

The scheduler has two modes, chosen by a memory-saturation flag from outside. The flag is raised when the miss-handling resources are nearly full. While the flag is low, all ready warps share issue in round-robin order. While it is high, one warp becomes the owner. Only the owner may issue memory instructions, and any ready warp may still issue compute work. The owner keeps memory issue until its next instruction is held back by a dependency. The scheduler then moves ownership to the lowest-indexed warp that has a memory instruction ready. When the flag falls, ownership is dropped.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset the round-robin pointer sits at the last warp, so the first grant goes to the lowest-indexed eligible warp. With no instruction buffer valid, `grant_o` is 0.
- R2: A warp whose `ibuf_valid_i` bit is 0, or whose `dep_i` bit is 1, is never granted.
- R3: With `mem_sat_i` low, the grant goes to the first eligible warp found after the last granted warp, wrapping from index NUM_WARPS-1 to 0. The operation type (`op_mem_i` bit, 1 = memory, 0 = compute) has no effect.
- R4: At most one warp is granted per cycle. `grant_o` is 1 exactly when at least one warp is eligible.
- R5: With `mem_sat_i` high, a warp whose instruction is a memory operation is granted only if it is the owner. Non-owner compute instructions stay eligible.
- R6: With `mem_sat_i` high and no owner held, the owner becomes the lowest-indexed warp with a valid memory instruction and no dependency. That warp can be granted in the same cycle.
- R7: With `mem_sat_i` high, an owner is kept from cycle to cycle as long as it does not have a valid instruction that is blocked by a dependency. This holds even when its buffer is empty, and other warps' memory instructions then wait.
- R8: An owner with a valid instruction and a dependency loses ownership in that cycle. The lowest-indexed unblocked memory candidate replaces it.
- R9: If no memory candidate exists when an owner is needed, no owner is held and no memory instruction issues. Compute instructions still issue.
- R10: When `mem_sat_i` is low at a clock edge, the owner is cleared. The next saturated period chooses a fresh owner by the rule of R6.
- R11: The round-robin pointer moves only on a cycle with a grant. An idle cycle leaves the next search start unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ibuf_valid_i | input | NUM_WARPS | Per-warp: instruction buffer holds an instruction |
| op_mem_i | input | NUM_WARPS | Per-warp: 1 = memory instruction, 0 = compute |
| dep_i | input | NUM_WARPS | Per-warp: scoreboard dependency blocks the instruction |
| mem_sat_i | input | 1 | Memory system saturated; selects memory-priority mode |
| grant_o | output | 1 | A warp is issued this cycle |
| grant_wid_o | output | $clog2(NUM_WARPS) | Index of the issued warp |

## Verification
The bench targets ownership hand-off in these cases:
- An owner with an empty buffer. A design that drops such an owner would let another warp's memory instruction through, which breaks R7.
- An owner blocked by a dependency while a lower-indexed warp is also blocked. A design that picks the wrong replacement would grant the wrong warp, or would grant a blocked one.
- The saturation flag falling and rising again. A design that keeps the old owner across an unsaturated period would go on serving that stale warp.

The round-robin pointer is tested across idle cycles and across the wrap point. A pointer that advances without a grant would skip a warp. Long random runs check each memory grant in saturated mode against the bench's own record of the owner.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic {
    MODE_EQUAL = 1'b0,
    MODE_MEMPRI = 1'b1
  } sched_mode_e;
endpackage

// File: rtl/wis_rr_arb.sv
module wis_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    gnt_o = 1'b0;
    idx_o = '0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_i) + off) % N;
      if (!gnt_o && req_i[idx]) begin
        gnt_o = 1'b1;
        idx_o = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_low_pick.sv
module wis_low_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int w = N - 1; w >= 0; w--) begin
      if (cand_i[w]) begin
        found_o = 1'b1;
        idx_o   = IW'(w);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] ibuf_valid_i,
  input  logic [NUM_WARPS-1:0] op_mem_i,
  input  logic [NUM_WARPS-1:0] dep_i,
  input  logic                 mem_sat_i,
  output logic                 grant_o,
  output logic [WID_W-1:0]     grant_wid_o
);
  sched_mode_e            mode;
  logic [NUM_WARPS-1:0]   ready, mem_cand, owner_mask, elig;
  logic [WID_W-1:0]       last_q, owner_q, eff_owner, cand_idx;
  logic                   owner_vld_q, owner_blocked, keep_owner, cand_found, eff_vld;

  assign mode     = mem_sat_i ? MODE_MEMPRI : MODE_EQUAL;
  assign ready    = ibuf_valid_i & ~dep_i;
  assign mem_cand = ready & op_mem_i;

  wis_low_pick #(.N(NUM_WARPS)) i_owner_pick (
    .cand_i (mem_cand),
    .found_o(cand_found),
    .idx_o  (cand_idx)
  );

  // owner loses its slot only when its pending instruction is stuck on a dependency
  assign owner_blocked = owner_vld_q & ibuf_valid_i[owner_q] & dep_i[owner_q];
  assign keep_owner    = owner_vld_q & ~owner_blocked;
  assign eff_vld       = keep_owner | cand_found;
  assign eff_owner     = keep_owner ? owner_q : cand_idx;

  always_comb begin
    owner_mask = '0;
    if (eff_vld) owner_mask[eff_owner] = 1'b1;
    if (mode == MODE_MEMPRI) elig = ready & (~op_mem_i | owner_mask);
    else                     elig = ready;
  end

  wis_rr_arb #(.N(NUM_WARPS)) i_rr (
    .req_i (elig),
    .last_i(last_q),
    .gnt_o (grant_o),
    .idx_o (grant_wid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q      <= WID_W'(NUM_WARPS - 1);
      owner_q     <= '0;
      owner_vld_q <= 1'b0;
    end else begin
      if (grant_o) last_q <= grant_wid_o;
      owner_vld_q <= (mode == MODE_MEMPRI) & eff_vld;
      owner_q     <= eff_owner;
    end
  end
endmodule

// File: rtl/wis_chk.sv
module wis_chk #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_WARPS-1:0] ibuf_valid_i,
  input logic [NUM_WARPS-1:0] op_mem_i,
  input logic [NUM_WARPS-1:0] dep_i,
  input logic                 mem_sat_i,
  input logic                 grant_o,
  input logic [WID_W-1:0]     grant_wid_o,
  input logic [WID_W-1:0]     owner_q,
  input logic                 owner_vld_q
);
  // R2
  granted_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (ibuf_valid_i[grant_wid_o] && !dep_i[grant_wid_o]));

  // R4
  work_conserving_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_sat_i && |(ibuf_valid_i & ~dep_i)) |-> grant_o);

  // R5
  owner_only_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sat_i && grant_o && op_mem_i[grant_wid_o]) |=>
      (owner_vld_q && owner_q == $past(grant_wid_o)));

  // R7
  owner_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sat_i && owner_vld_q && !(ibuf_valid_i[owner_q] && dep_i[owner_q])) |=>
      (owner_vld_q && owner_q == $past(owner_q)));

  // R10
  owner_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_sat_i |=> !owner_vld_q);
endmodule

bind warp_issue_sched wis_chk #(.NUM_WARPS(NUM_WARPS)) i_wis_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ibuf_valid_i(ibuf_valid_i),
  .op_mem_i    (op_mem_i),
  .dep_i       (dep_i),
  .mem_sat_i   (mem_sat_i),
  .grant_o     (grant_o),
  .grant_wid_o (grant_wid_o),
  .owner_q     (owner_q),
  .owner_vld_q (owner_vld_q)
);

// File: tb/test_warp_issue_sched.sv
`timescale 1ns/1ps
module test_warp_issue_sched;
  localparam int N = 8;
  localparam int WW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  ibuf_valid_i = '0, op_mem_i = '0, dep_i = '0;
  logic          mem_sat_i = 1'b0;
  logic          grant_o;
  logic [WW-1:0] grant_wid_o;

  int errors = 0, checks = 0;
  int m_last = N - 1, m_own = 0;
  bit m_own_v = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  warp_issue_sched #(.NUM_WARPS(N)) i_warp_issue_sched (.*);

  // behavioural model: returns expected grant (-1 = none), updates its state
  task automatic model(output int exp_w, output bit mem_grant_ok);
    int eo = -1;
    bit blocked;
    bit [N-1:0] el;
    exp_w = -1;
    mem_grant_ok = 1;
    if (mem_sat_i) begin
      blocked = m_own_v && ibuf_valid_i[m_own] && dep_i[m_own];
      if (m_own_v && !blocked) eo = m_own;
      else
        for (int w = 0; w < N; w++)
          if (eo < 0 && ibuf_valid_i[w] && op_mem_i[w] && !dep_i[w]) eo = w;
    end
    for (int w = 0; w < N; w++)
      el[w] = ibuf_valid_i[w] && !dep_i[w] && (!mem_sat_i || !op_mem_i[w] || w == eo);
    for (int off = 1; off <= N; off++) begin
      int k = (m_last + off) % N;
      if (exp_w < 0 && el[k]) exp_w = k;
    end
    if (grant_o && mem_sat_i && op_mem_i[grant_wid_o] && int'(grant_wid_o) != eo) mem_grant_ok = 0;
    if (exp_w >= 0) m_last = exp_w;
    m_own_v = mem_sat_i && (eo >= 0);
    if (eo >= 0) m_own = eo;
  endtask

  task automatic compare(string tag, int hard);
    int act, exp_w;
    bit ok;
    act = grant_o ? int'(grant_wid_o) : -1;
    model(exp_w, ok);
    checks++;
    if (act != exp_w) begin
      errors++;
      $display("FAIL %s: grant actual=%0d expected=%0d", tag, act, exp_w);
    end
    if (hard != -2) begin
      checks++;
      if (act != hard) begin
        errors++;
        $display("FAIL %s: grant actual=%0d expected=%0d (directed)", tag, act, hard);
      end
    end
    if (mem_sat_i) begin
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL R5: non-owner memory grant actual=%0d expected=owner %0d", act, m_own);
      end
    end
  endtask

  task automatic step(logic [N-1:0] v, logic [N-1:0] m, logic [N-1:0] d, logic s,
                      string tag, int hard);
    @(posedge clk_i);
    #1;
    ibuf_valid_i = v; op_mem_i = m; dep_i = d; mem_sat_i = s;
    @(negedge clk_i);
    compare(tag, hard);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step(8'h00, 8'h00, 8'h00, 0, "R1", -1);
    step(8'hff, 8'h00, 8'h00, 0, "R1", 0);
    for (int k = 1; k < N; k++) step(8'hff, 8'haa, 8'h00, 0, "R3", k);
    step(8'hff, 8'h55, 8'h00, 0, "R3", 0);
    step(8'hff, 8'h00, 8'h06, 0, "R2", 3);
    step(8'h00, 8'h00, 8'h00, 0, "R11", -1);
    step(8'hff, 8'h00, 8'h00, 0, "R11", 4);
    step(8'h20, 8'h00, 8'h20, 0, "R4", -1);
    step(8'h24, 8'h24, 8'h00, 1, "R6", 2);
    step(8'h24, 8'h24, 8'h00, 1, "R5", 2);
    step(8'h64, 8'h24, 8'h00, 1, "R5", 6);
    step(8'h24, 8'h24, 8'h04, 1, "R8", 5);
    step(8'h24, 8'h24, 8'h00, 1, "R7", 5);
    step(8'h04, 8'h04, 8'h00, 1, "R7", -1);
    step(8'h44, 8'h04, 8'h00, 1, "R5", 6);
    step(8'h64, 8'h24, 8'h24, 1, "R9", 6);
    step(8'h20, 8'h20, 8'h00, 1, "R6", 5);
    step(8'h24, 8'h24, 8'h00, 0, "R10", 2);
    step(8'h24, 8'h24, 8'h00, 1, "R10", 2);
    for (int c = 0; c < 4000; c++) begin
      logic s;
      s = (c / 200) % 2 == 1;
      step(N'($urandom), N'($urandom), N'($urandom) & N'($urandom), s,
           s ? "R5" : "R3", -2);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule